// File: doc/BRIEF.md
# Power-Fail Detect and Reboot Policy

This block sits in the always-on clock domain and watches three platform supply signals. The first is the main supply power-good, the second is the processor regulator power-good, and the third is the active-low resume-well reset. It brings each signal into its clock domain and combines the two power-good signals into one. It tracks the order in which the signals fall. From that order it tells a partial dropout apart from a full power failure.

In a partial dropout, power-good falls while the resume well stays out of reset. When power-good returns, the block always asks for a reboot. In a full failure, the resume-well reset also asserts before power-good comes back. When the supplies return, an after-loss policy input decides the outcome: either a reboot request, or an off state that lasts until a wake request arrives.

Two sticky flags record the events, one for any power failure and one for a full failure. Software clears each flag by writing a one to its bit through a small write port. The flags are not cleared when power recovers.

Top module: `pwr_fail_arbiter`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pwr_good`, `fail_flag`, `full_flag`, `reboot_pulse` and `stay_off` are all 0.
- R2: `pwr_good` is the AND of `supply_ok` and `vreg_ok`, delayed by the two-flop synchronizer. It follows an input change on the second rising edge after that change.
- R3: If `pwr_good` falls while the resume well is out of reset (`resume_rst_n` high), `fail_flag` is set one edge after `pwr_good` falls, and `full_flag` stays 0.
- R4: When a partial dropout ends, `reboot_pulse` goes high for exactly one cycle, one edge after `pwr_good` returns high. This happens whatever the value of `after_loss_on`.
- R5: If `resume_rst_n` goes low before `pwr_good` returns high, the event is a full failure. `full_flag` and `fail_flag` are both set one edge after the synchronized reset is seen low.
- R6: After a full failure with `after_loss_on` = 1, a one-cycle `reboot_pulse` is issued one edge after both the synchronized power-good and the synchronized resume-well reset are high.
- R7: After a full failure with `after_loss_on` = 0, no pulse is issued. `stay_off` goes high at the edge where a reboot would otherwise have been issued, and stays high. When `wake_req` is sampled high, `reboot_pulse` is 1 and `stay_off` is 0 after that same edge.
- R8: The flags are cleared only by a cycle with `clr_we` high, where `clr_bits[0]` = 1 clears `fail_flag` and `clr_bits[1]` = 1 clears `full_flag`. A zero in a bit leaves that flag unchanged. Power-good recovery does not clear the flags. A set in the same cycle as a clear wins.
- R9: A low pulse on `supply_ok` that starts and ends between two rising edges has no effect on any output.
- R10: While power-good is low, the block keeps `pwr_good` low and issues no reboot, with no time limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok | input | 1 | Main supply power-good, asynchronous |
| vreg_ok | input | 1 | Processor regulator power-good, asynchronous |
| resume_rst_n | input | 1 | Active-low resume-well reset, asynchronous |
| after_loss_on | input | 1 | Policy after a full failure: 1 means reboot, 0 means stay off |
| wake_req | input | 1 | Synchronous wake request that leaves the off state |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 2 | Write-one-to-clear mask: bit 0 is the fail flag, bit 1 is the full flag |
| pwr_good | output | 1 | Synchronized combined power-good |
| fail_flag | output | 1 | Sticky power-fail flag |
| full_flag | output | 1 | Sticky full-power-failure flag |
| reboot_pulse | output | 1 | One-cycle reboot request |
| stay_off | output | 1 | High while the block holds the system off |

## Verification
An input change reaches `pwr_good` on the second rising edge after it, because of the two synchronizer flops. The flags, `reboot_pulse` and `stay_off` come from a decision register behind the synchronizer, so they change on the third edge. The exception is `wake_req`: it is already synchronous and acts on the first edge. The bench drives every input on a falling edge and counts rising edges from there. It samples on the falling edge after the edge where a result is due. It also samples one cycle earlier, to confirm the result has not arrived too soon. A second sample one cycle after each pulse confirms the pulse lasts only one cycle.

// File: rtl/pwr_fail_arbiter.sv
module pwr_fail_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             vreg_ok,
  input  logic             resume_rst_n,
  input  logic             after_loss_on,
  input  logic             wake_req,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_bits,
  output logic             pwr_good,
  output logic             fail_flag,
  output logic             full_flag,
  output logic             reboot_pulse,
  output logic             stay_off
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [2:0] {ST_INIT, ST_RUN, ST_DROP, ST_FULL, ST_OFF} st_t;

  logic [LAST:0] sup_q, vrg_q, rsm_q;
  st_t           st;
  logic          good, rsm_ok, fail_set, full_set, running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= '0;
      vrg_q <= '0;
      rsm_q <= '0;
    end else begin
      sup_q <= {sup_q[LAST-1:0], supply_ok};
      vrg_q <= {vrg_q[LAST-1:0], vreg_ok};
      rsm_q <= {rsm_q[LAST-1:0], resume_rst_n};
    end
  end

  assign good     = sup_q[LAST] & vrg_q[LAST];
  assign rsm_ok   = rsm_q[LAST];
  assign pwr_good = good;
  assign running  = (st == ST_RUN);
  assign stay_off = (st == ST_OFF);

  assign full_set = ((st == ST_RUN) || (st == ST_DROP)) && !rsm_ok;
  assign fail_set = full_set || ((st == ST_RUN) && !good);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_INIT;
      reboot_pulse <= 1'b0;
    end else begin
      reboot_pulse <= 1'b0;
      case (st)
        ST_INIT: if (good && rsm_ok) st <= ST_RUN;
        ST_RUN: begin
          if (!rsm_ok)    st <= ST_FULL;
          else if (!good) st <= ST_DROP;
        end
        ST_DROP: begin
          if (!rsm_ok) st <= ST_FULL;
          else if (good) begin
            st           <= ST_RUN;
            reboot_pulse <= 1'b1;
          end
        end
        ST_FULL: begin
          if (good && rsm_ok) begin
            if (after_loss_on) begin
              st           <= ST_RUN;
              reboot_pulse <= 1'b1;
            end else begin
              st <= ST_OFF;
            end
          end
        end
        ST_OFF: begin
          if (wake_req && good && rsm_ok) begin
            st           <= ST_RUN;
            reboot_pulse <= 1'b1;
          end
        end
        default: st <= ST_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag <= 1'b0;
      full_flag <= 1'b0;
    end else begin
      fail_flag <= fail_set | (fail_flag & ~(clr_we & clr_bits[0]));
      full_flag <= full_set | (full_flag & ~(clr_we & clr_bits[1]));
    end
  end

endmodule

module pwr_fail_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic vreg_ok,
  input logic pwr_good,
  input logic fail_flag,
  input logic full_flag,
  input logic reboot_pulse,
  input logic stay_off,
  input logic running
);

  a_r2_good_needs_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> $past(supply_ok && vreg_ok, 2));

  a_r3_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $fell(pwr_good)) |=> fail_flag);

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_pulse |=> !reboot_pulse);

  a_r5_full_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> fail_flag);

  a_r7_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stay_off |-> !reboot_pulse);

endmodule

bind pwr_fail_arbiter pwr_fail_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vreg_ok(vreg_ok),
  .pwr_good(pwr_good), .fail_flag(fail_flag), .full_flag(full_flag),
  .reboot_pulse(reboot_pulse), .stay_off(stay_off), .running(running)
);

// File: tb/pwr_fail_arbiter_tb.sv
module pwr_fail_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, vreg_ok = 1'b0, resume_rst_n = 1'b0;
  logic after_loss_on = 1'b0, wake_req = 1'b0, clr_we = 1'b0;
  logic [1:0] clr_bits = 2'b00;
  logic pwr_good, fail_flag, full_flag, reboot_pulse, stay_off;
  int checks = 0, failures = 0, pulses = 0;

  always #2 clk = ~clk;

  pwr_fail_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vreg_ok(vreg_ok),
    .resume_rst_n(resume_rst_n), .after_loss_on(after_loss_on),
    .wake_req(wake_req), .clr_we(clr_we), .clr_bits(clr_bits),
    .pwr_good(pwr_good), .fail_flag(fail_flag), .full_flag(full_flag),
    .reboot_pulse(reboot_pulse), .stay_off(stay_off)
  );

  always @(negedge clk) if (reboot_pulse) pulses++;

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flags(input logic [1:0] m);
    clr_we = 1'b1; clr_bits = m;
    edges(1);
    clr_we = 1'b0; clr_bits = 2'b00;
  endtask

  task automatic t_reset();
    edges(3);
    chk(pwr_good, 1'b0, "R1 pwr_good in reset");
    chk(fail_flag | full_flag, 1'b0, "R1 flags in reset");
    chk(reboot_pulse | stay_off, 1'b0, "R1 pulse/off in reset");
    rst_n = 1'b1;
    edges(1);
    chk(pwr_good, 1'b0, "R1 pwr_good after release");
    supply_ok = 1'b1; vreg_ok = 1'b1; resume_rst_n = 1'b1;
    edges(1);
    chk(pwr_good, 1'b0, "R2 not yet after one edge");
    edges(1);
    chk(pwr_good, 1'b1, "R2 good after two edges");
    edges(3);
    chk(reboot_pulse | fail_flag, 1'b0, "R1 no event on power-up");
  endtask

  task automatic t_partial();
    int p0;
    after_loss_on = 1'b0;
    vreg_ok = 1'b0;
    edges(2);
    chk(pwr_good, 1'b0, "R2 AND with regulator low");
    chk(fail_flag, 1'b0, "R3 flag not before its edge");
    edges(1);
    chk(fail_flag, 1'b1, "R3 fail flag set");
    chk(full_flag, 1'b0, "R3 full flag stays clear");
    p0 = pulses;
    edges(1000);
    chk(pwr_good, 1'b0, "R10 still held low");
    chk(pulses != p0, 1'b0, "R10 no reboot while low");
    vreg_ok = 1'b1;
    edges(2);
    chk(pwr_good, 1'b1, "R2 good restored");
    chk(reboot_pulse, 1'b0, "R4 pulse not early");
    edges(1);
    chk(reboot_pulse, 1'b1, "R4 reboot despite policy 0");
    edges(1);
    chk(reboot_pulse, 1'b0, "R4 pulse one cycle");
    chk(fail_flag, 1'b1, "R8 recovery keeps flag");
    clear_flags(2'b10);
    chk(fail_flag, 1'b1, "R8 zero bit leaves flag");
    clear_flags(2'b01);
    chk(fail_flag, 1'b0, "R8 one bit clears flag");
  endtask

  task automatic t_full(input logic pol);
    int p0;
    after_loss_on = pol;
    supply_ok = 1'b0;
    edges(3);
    chk(fail_flag, 1'b1, "R3 fail flag on supply drop");
    resume_rst_n = 1'b0;
    edges(2);
    chk(full_flag, 1'b0, "R5 full not before its edge");
    edges(1);
    chk(full_flag, 1'b1, "R5 full flag set");
    chk(fail_flag, 1'b1, "R5 fail flag set");
    p0 = pulses;
    supply_ok = 1'b1; resume_rst_n = 1'b1;
    edges(3);
    if (pol) begin
      chk(reboot_pulse, 1'b1, "R6 reboot after full failure");
      chk(stay_off, 1'b0, "R6 not off");
      edges(1);
      chk(reboot_pulse, 1'b0, "R6 pulse one cycle");
    end else begin
      chk(stay_off, 1'b1, "R7 stay off");
      edges(20);
      chk(stay_off, 1'b1, "R7 still off");
      chk(pulses != p0, 1'b0, "R7 no pulse while off");
      wake_req = 1'b1;
      edges(1);
      wake_req = 1'b0;
      chk(reboot_pulse, 1'b1, "R7 wake reboots");
      chk(stay_off, 1'b0, "R7 off released");
      edges(1);
      chk(reboot_pulse, 1'b0, "R7 pulse one cycle");
    end
    chk(full_flag, 1'b1, "R8 full flag survives recovery");
    clear_flags(2'b11);
    chk(full_flag | fail_flag, 1'b0, "R8 both flags cleared");
  endtask

  task automatic t_glitch();
    int p0;
    p0 = pulses;
    @(posedge clk);
    #1 supply_ok = 1'b0;
    #2 supply_ok = 1'b1;
    edges(5);
    chk(pwr_good, 1'b1, "R9 glitch unseen on pwr_good");
    chk(fail_flag, 1'b0, "R9 glitch sets no flag");
    chk(pulses != p0, 1'b0, "R9 glitch no reboot");
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_partial();
        t_full(1'b1);
        t_full(1'b0);
        t_glitch();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule